// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Window Controller

This block decides which sampled words reach a circular sample memory around a trigger event. Once armed, it takes samples at a programmable rate and writes them into the ring without stopping, so the memory always holds the most recent history. When a trigger is seen it stores a programmed number of further samples, then stops writing and raises a done flag. A readback pointer then walks the ring from the oldest valid word to the newest.

The 32 input channels form four byte-wide groups, and each group can be switched off. Only the enabled groups are packed into the memory words, byte after byte, so fewer enabled groups give proportionally deeper capture. Capture lengths are given in blocks of four samples and are written as the block count minus one. The memory array itself sits outside this block. Each write is offered as a strobe, an address and a 32-bit word.

Top module: `capture_window_ctrl`

## Requirements
- R1: After reset, done_o is 0, mem_we_o is 0 and rd_len_o is 0.
- R2: While capturing, one sample is taken every (divider_i + 1) clock cycles. The first sample is taken at the first clock edge after the arm edge.
- R3: grp_off_i[g] = 1 drops channel byte g (sample_i[8g+7:8g]), and this field matches bits 5..2 of the host flag word. The enabled bytes of each sample are appended in ascending group order to a byte stream. Stream byte 4w+k becomes byte k (bits 8k+7:8k) of memory word w. If all four groups are disabled, group 0 alone is captured.
- R4: Word w of a capture is written to address w mod 2^ADDR_W, one mem_we_o pulse per word, in order.
- R5: trig_i counts only in a cycle that takes a sample. The post-trigger phase begins at the first sample at or after that one whose index since arm is a multiple of four.
- R6: Exactly 4*(delay_groups_i + 1) samples are stored from the first post-trigger sample on, and then writing stops.
- R7: done_o rises one cycle after the final write and holds until the next arm. While it is high there are no writes and trig_i has no effect.
- R8: rd_len_o equals the smallest of: words written, (read_groups_i + 1) times the enabled group count n, and floor(2^ADDR_W / n) * n.
- R9: While done_o is high, rd_addr_o first points at the oldest valid word (final write pointer minus rd_len_o) and advances by one, modulo the depth, for each cycle with rd_next_i high.
- R10: arm_i restarts a capture at any time. done_o is 0 in the next cycle and the next write goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start or restart a capture |
| trig_i | input | 1 | Trigger event |
| sample_i | input | 32 | Channel inputs, four byte groups |
| divider_i | input | 24 | Sample period minus one, in clocks |
| read_groups_i | input | 16 | Total capture length in four-sample blocks, minus one |
| delay_groups_i | input | 16 | Post-trigger length in four-sample blocks, minus one |
| grp_off_i | input | 4 | Per-group disable, 1 = disabled |
| rd_next_i | input | 1 | Advance the readback pointer |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | 32 | Packed memory word |
| done_o | output | 1 | Capture complete |
| rd_addr_o | output | ADDR_W | Readback address |
| rd_len_o | output | ADDR_W+1 | Number of valid words to read back |

## Verification
The bench sweeps all sixteen group-disable patterns and two sample rates. It uses triggers that arrive both on and off a four-sample boundary. A design that skipped the alignment would finish early and pack a shifted stream. Cases where three groups are enabled overflow the ring, which catches a capacity clamp that ignores the non-power-of-two packing. A case where the read count is shorter than the data written catches a readback start that trusts the write count alone. A trigger pulse between sample strobes and trigger pulses after completion both expose a design that listens at the wrong time: it would end at the wrong cycle or write after done.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    CW_IDLE = 2'd0,
    CW_PRE  = 2'd1,
    CW_POST = 2'd2,
    CW_DONE = 2'd3
  } cw_state_e;

  localparam int unsigned CW_BLOCK = 4;
endpackage

// File: rtl/cw_rate_div.sv
module cw_rate_div #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] divider_i,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign stb_o = run_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)
      cnt_d = '0;
    else if (cnt_q == '0)
      cnt_d = divider_i;
    else
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cw_lane_pack.sv
module cw_lane_pack #(
  parameter  int GROUPS  = 4,
  parameter  int GROUP_W = 8,
  localparam int WORD_W  = GROUPS * GROUP_W,
  localparam int CNT_W   = $clog2(GROUPS + 1)
) (
  input  logic [WORD_W-1:0] sample_i,
  input  logic [GROUPS-1:0] en_i,
  output logic [WORD_W-1:0] packed_o,
  output logic [CNT_W-1:0]  nbytes_o
);
  always_comb begin
    int idx;
    idx      = 0;
    packed_o = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (en_i[g]) begin
        packed_o[idx*GROUP_W +: GROUP_W] = sample_i[g*GROUP_W +: GROUP_W];
        idx = idx + 1;
      end
    end
    nbytes_o = CNT_W'(idx);
  end
endmodule

// File: rtl/cw_word_accum.sv
module cw_word_accum #(
  parameter  int GROUPS  = 4,
  parameter  int GROUP_W = 8,
  localparam int WORD_W  = GROUPS * GROUP_W,
  localparam int ACC_W   = (GROUPS - 1) * GROUP_W,
  localparam int MRG_W   = WORD_W + ACC_W,
  localparam int CNT_W   = $clog2(GROUPS + 1),
  localparam int PTR_W   = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] bytes_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [PTR_W-1:0]  cnt_q, cnt_d;
  logic              wv_q, wv_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [MRG_W-1:0]  merged;
  int                total;

  always_comb begin
    merged = MRG_W'(acc_q) | (MRG_W'(bytes_i) << (int'(cnt_q) * GROUP_W));
    total  = int'(cnt_q) + int'(nbytes_i);
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    wv_d   = 1'b0;
    word_d = word_q;
    if (clear_i) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (push_i) begin
      if (total >= GROUPS) begin
        wv_d   = 1'b1;
        word_d = merged[WORD_W-1:0];
        acc_d  = merged[WORD_W +: ACC_W];
        cnt_d  = PTR_W'(total - GROUPS);
      end else begin
        acc_d = merged[ACC_W-1:0];
        cnt_d = PTR_W'(total);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      wv_q   <= 1'b0;
      word_q <= '0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      wv_q   <= wv_d;
      word_q <= word_d;
    end
  end

  assign word_valid_o = wv_q;
  assign word_o       = word_q;
endmodule

// File: rtl/capture_window_ctrl.sv
module capture_window_ctrl
  import cw_pkg::*;
#(
  parameter  int ADDR_W  = 6,
  parameter  int GROUPS  = 4,
  parameter  int GROUP_W = 8,
  parameter  int CNT_W   = 16,
  parameter  int DIV_W   = 24,
  localparam int WORD_W  = GROUPS * GROUP_W,
  localparam int DEPTH   = 1 << ADDR_W,
  localparam int GCNT_W  = $clog2(GROUPS + 1),
  localparam int LIM_W   = CNT_W + GCNT_W + 1,
  localparam int SIDX_W  = $clog2(CW_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic [DIV_W-1:0]  divider_i,
  input  logic [CNT_W-1:0]  read_groups_i,
  input  logic [CNT_W-1:0]  delay_groups_i,
  input  logic [GROUPS-1:0] grp_off_i,
  input  logic              rd_next_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W:0]   rd_len_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cw_state_e         state_q, state_d;
  logic [SIDX_W-1:0] sidx_q, sidx_d;
  logic              trig_seen_q, trig_seen_d;
  logic [CNT_W-1:0]  post_left_q, post_left_d;
  logic [ADDR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [ADDR_W:0]   wcount_q, wcount_d;
  logic [ADDR_W-1:0] rd_off_q, rd_off_d;
  logic              done_q, done_d;

  logic [GROUPS-1:0] en;
  logic              run, stb;
  logic [WORD_W-1:0] packed_bytes;
  logic [GCNT_W-1:0] n_bytes;
  logic              word_valid;
  logic [ADDR_W:0]   cap;
  logic [LIM_W-1:0]  lim;

  assign en  = (&grp_off_i) ? GROUPS'(1) : ~grp_off_i;
  assign run = ((state_q == CW_PRE) || (state_q == CW_POST)) && !arm_i;

  cw_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_core_n), .run_i(run),
    .divider_i(divider_i), .stb_o(stb)
  );

  cw_lane_pack #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_pack (
    .sample_i(sample_i), .en_i(en),
    .packed_o(packed_bytes), .nbytes_o(n_bytes)
  );

  cw_word_accum #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_acc (
    .clk(clk), .rst_n(rst_core_n), .clear_i(arm_i), .push_i(stb),
    .bytes_i(packed_bytes), .nbytes_i(n_bytes),
    .word_valid_o(word_valid), .word_o(mem_wdata_o)
  );

  // ring capacity in whole samples' worth of words for the current packing
  always_comb begin
    cap = (ADDR_W+1)'(DEPTH);
    for (int k = 1; k <= GROUPS; k++)
      if (int'(n_bytes) == k) cap = (ADDR_W+1)'((DEPTH / k) * k);
  end

  always_comb begin
    lim = (LIM_W'(read_groups_i) + 1'b1) * LIM_W'(n_bytes);
    if (LIM_W'(wcount_q) < lim) rd_len_o = wcount_q;
    else                        rd_len_o = (ADDR_W+1)'(lim);
  end

  always_comb begin
    state_d     = state_q;
    sidx_d      = sidx_q;
    trig_seen_d = trig_seen_q;
    post_left_d = post_left_q;
    wr_ptr_d    = wr_ptr_q;
    wcount_d    = wcount_q;
    rd_off_d    = rd_off_q;
    if (arm_i) begin
      state_d     = CW_PRE;
      sidx_d      = '0;
      trig_seen_d = 1'b0;
      post_left_d = '0;
      wr_ptr_d    = '0;
      wcount_d    = '0;
      rd_off_d    = '0;
    end else begin
      if (word_valid) begin
        wr_ptr_d = wr_ptr_q + 1'b1;
        if (wcount_q < cap) wcount_d = wcount_q + 1'b1;
      end
      if (stb) begin
        sidx_d = sidx_q + 1'b1;
        case (state_q)
          CW_PRE: begin
            if ((trig_i || trig_seen_q) && (sidx_q == '0)) begin
              state_d     = CW_POST;
              post_left_d = delay_groups_i;
            end else if (trig_i) begin
              trig_seen_d = 1'b1;
            end
          end
          CW_POST: begin
            if (&sidx_q) begin
              if (post_left_q == '0) state_d = CW_DONE;
              else                   post_left_d = post_left_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (done_q && rd_next_i) rd_off_d = rd_off_q + 1'b1;
    end
    done_d = (state_q == CW_DONE) && !arm_i;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q     <= CW_IDLE;
      sidx_q      <= '0;
      trig_seen_q <= 1'b0;
      post_left_q <= '0;
      wr_ptr_q    <= '0;
      wcount_q    <= '0;
      rd_off_q    <= '0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      sidx_q      <= sidx_d;
      trig_seen_q <= trig_seen_d;
      post_left_q <= post_left_d;
      wr_ptr_q    <= wr_ptr_d;
      wcount_q    <= wcount_d;
      rd_off_q    <= rd_off_d;
      done_q      <= done_d;
    end
  end

  assign mem_we_o   = word_valid;
  assign mem_addr_o = wr_ptr_q;
  assign done_o     = done_q;
  assign rd_addr_o  = wr_ptr_q - rd_len_o[ADDR_W-1:0] + rd_off_q;
endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_i,
  input logic              done_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W:0]   rd_len_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] exp_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        exp_addr_q <= '0;
    else if (arm_i)    exp_addr_q <= '0;
    else if (mem_we_o) exp_addr_q <= exp_addr_q + 1'b1;
  end

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !arm_i |=> done_o);

  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_we_o);

  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !done_o);

  assert_addr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o && !arm_i |-> mem_addr_o == exp_addr_q);

  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_len_o <= (ADDR_W+1)'(DEPTH));
endmodule

bind capture_window_ctrl cw_checker #(.ADDR_W(ADDR_W)) u_cw_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .done_o(done_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .rd_len_o(rd_len_o)
);

// File: tb/capture_window_ctrl_tb.sv
module capture_window_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm_i, trig_i, rd_next_i;
  logic [31:0]   sample_i;
  logic [23:0]   divider_i;
  logic [15:0]   read_groups_i, delay_groups_i;
  logic [3:0]    grp_off_i;
  logic          mem_we_o, done_o;
  logic [AW-1:0] mem_addr_o, rd_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [AW:0]   rd_len_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] bmem [DEP];
  int n_en;
  logic [3:0] en_b;
  int dv;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_window_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i),
    .sample_i(sample_i), .divider_i(divider_i), .read_groups_i(read_groups_i),
    .delay_groups_i(delay_groups_i), .grp_off_i(grp_off_i), .rd_next_i(rd_next_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .done_o(done_o), .rd_addr_o(rd_addr_o), .rd_len_o(rd_len_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] pat(input int c);
    return 32'(c) * 32'h01030507 + 32'h9E3779B9;
  endfunction

  function automatic int nth_group(input int q);
    int seen = 0;
    for (int g = 0; g < 4; g++)
      if (en_b[g]) begin
        if (seen == q) return g;
        seen++;
      end
    return 0;
  endfunction

  // R3: word w is stream bytes 4w..4w+3, built from enabled groups in ascending order
  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int b = 4 * w + k;
      int j = b / n_en;
      int g = nth_group(b % n_en);
      logic [31:0] s = pat(1 + j * (dv + 1));
      r[k*8 +: 8] = s[g*8 +: 8];
    end
    return r;
  endfunction

  task automatic run_case(input logic [3:0] mask, input int d, input int rc,
                          input int dc, input int t);
    int p, l, wtot, cl, first_done, nw, late_w, exp_len, cap;
    bit dropped;
    en_b = (mask == 4'hF) ? 4'h1 : ~mask;
    n_en = $countones(en_b);
    dv = d;
    p = ((t + 3) / 4) * 4;
    l = p + 4 * (dc + 1) - 1;
    wtot = (l + 1) * n_en / 4;
    cl = 1 + l * (d + 1);
    @(negedge clk);
    grp_off_i = mask;
    divider_i = 24'(d);
    read_groups_i = 16'(rc);
    delay_groups_i = 16'(dc);
    arm_i = 1'b1;
    trig_i = 1'b0;
    sample_i = pat(0);
    first_done = -1; nw = 0; late_w = 0; dropped = 0;
    for (int c = 0; c <= cl + 10; c++) begin
      @(negedge clk);
      if (c == 0) chk(done_o == 1'b0, "R10 done cleared after arm", done_o, 0);
      if (mem_we_o) begin
        if (first_done >= 0) late_w++;
        else begin
          chk(int'(mem_addr_o) == nw % DEP, "R4 write address", mem_addr_o, nw % DEP);
          bmem[mem_addr_o] = mem_wdata_o;
          nw++;
        end
      end
      if (done_o && first_done < 0) first_done = c;
      if (first_done >= 0 && !done_o) dropped = 1;
      arm_i = 1'b0;
      sample_i = pat(c + 1);
      // real trigger, an off-strobe pulse (R5), and pulses after done (R7)
      trig_i = (c + 1 == 1 + t * (d + 1)) || (d > 0 && c + 1 == 2) ||
               (c > cl + 1 && (c % 2) == 1);
    end
    trig_i = 1'b0;
    chk(first_done == cl + 1, "R2 R5 R6 done cycle", first_done, cl + 1);
    chk(nw == wtot, "R6 words written", nw, wtot);
    chk(late_w == 0, "R7 writes after done", late_w, 0);
    chk(dropped == 0, "R7 done held", dropped, 0);
    cap = (DEP / n_en) * n_en;
    exp_len = wtot;
    if ((rc + 1) * n_en < exp_len) exp_len = (rc + 1) * n_en;
    if (cap < exp_len) exp_len = cap;
    chk(int'(rd_len_o) == exp_len, "R8 readback length", rd_len_o, exp_len);
    for (int i = 0; i < exp_len; i++) begin
      int w = wtot - exp_len + i;
      chk(int'(rd_addr_o) == w % DEP, "R9 readback address", rd_addr_o, w % DEP);
      chk(bmem[rd_addr_o] == exp_word(w), "R3 packed word", bmem[rd_addr_o], exp_word(w));
      rd_next_i = 1'b1;
      @(negedge clk);
      rd_next_i = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    arm_i = 1'b0; trig_i = 1'b0; rd_next_i = 1'b0;
    sample_i = '0; divider_i = '0; read_groups_i = '0; delay_groups_i = '0;
    grp_off_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(mem_we_o == 1'b0, "R1 no write after reset", mem_we_o, 0);
    chk(rd_len_o == '0, "R1 length after reset", rd_len_o, 0);
    for (int m = 0; m < 16; m++)
      for (int di = 0; di < 2; di++) begin
        run_case(4'(m), di * 2, 3, 0, 5);
        run_case(4'(m), di * 2, 1, 1, 0);
        run_case(4'(m), di * 2, 15, 2, 13);
        run_case(4'(m), di * 2, 1, 0, 9);
      end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule